// File: doc/BRIEF.md
# Flash Host Word-Transfer Engine

This block sits between a simple host register port and the data pins of a flash device whose bus can be one, two, four or eight lanes wide. The host picks a phase (command, address or data), gives each phase its own lane-width code, and then writes a 32-bit word to one of four transmit aliases. The alias chosen sets how many bytes of that word go out: one, two, three or four. The engine shifts those bytes onto the bus and samples the same number of bytes back in the same bus steps. When the word is done it places the returned bytes in a receive register for the host to read.

For a read phase the engine leaves the bus undriven and only samples it; the host writes filler (normally all ones) to set the byte count. Chip-select can follow each word automatically, or be held under manual host control so that a command, its address bytes and its data all stay inside one select window. Two status flags support a polling driver. One says the transmitter is free. The other says a received word is waiting, and reading that word clears the flag.

Top module: `fhx_engine`

## Requirements
- R1: After reset, status reads 0x1 (transmitter free, no received word), chip-select is high, the bus is not driven, the data outputs sit at 0x00, and the configuration, enable and length registers read zero.
- R2: While enable bit 0 (offset 0x08) is zero, writes to the transmit aliases are ignored: no bus step happens and no received word appears.
- R3: A write to offset 0x14 sends four bytes; offsets 0x18, 0x1C and 0x20 send one, two and three bytes.
- R4: Lane-width code 0, 1, 2 or 3 uses 1, 2, 4 or 8 lanes (bits [W-1:0] of the data bus), one slice per clock. A word of n bytes takes n*8/W clocks, and the received word becomes available exactly that many clocks after the clock edge that takes the write.
- R5: Bytes leave least significant byte first. Each byte leaves most significant bits first. Data lanes above the active width hold the idle level.
- R6: Operation register (offset 0x28) bits [9:8] choose the phase: 0 command, 1 address, 2 or 3 data. The lane code for that phase comes from bits [1:0], [3:2] or [5:4] in the same order.
- R7: In the receive register (offset 0x24), the n returned bytes fill the n most significant bytes. The first byte back sits lowest among them, and the unused low bytes read zero.
- R8: With operation bit 23 set (read phase), the output enable stays low and the data outputs stay at the idle level for the whole word, whatever word was written.
- R9: Status (offset 0x04) bit 0 is low while a word is shifting, and bit 2 is high while a received word waits. A host read of offset 0x24 clears bit 2.
- R10: A transmit write that arrives while a word is shifting is dropped. The word in flight goes out and comes back unchanged.
- R11: With configuration bit 1 clear, chip-select is low exactly while a word shifts. With bit 1 set, chip-select follows configuration bit 0 (low when set) and stays low across and between words.
- R12: Clearing enable in mid-word stops shifting by the next clock, frees the transmitter and posts no received word. After enable is set again, a new word runs correctly.
- R13: Configuration bit 16 sets the idle level driven on every data output that is not carrying transmit data.
- R14: The data-out length register (offset 0x2C, 16 bits) reads back what was last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus slice per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Host register write strobe |
| bus_rd | input | 1 | Host register read strobe (consumes receive data) |
| bus_addr | input | ADDR_W | Host register byte offset |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data for bus_addr |
| fl_cs_n | output | 1 | Flash chip-select, active low |
| fl_shift | output | 1 | High during each bus step of a word |
| fl_dq_out | output | 8 | Data lanes toward the flash |
| fl_dq_oe | output | 1 | Output enable for fl_dq_out |
| fl_dq_in | input | 8 | Data lanes from the flash |

## Verification
The bench builds the engine with its default parameters: an 8-bit register offset and a 16-bit length register. These defaults reach every alias, all four lane codes and every phase selector value. They also reach the longest word, four bytes on a single lane in 32 steps, so the bench can time every word against n*8/W. A bus model on the negative edge rebuilds the transmitted bit stream, answers with a known byte pattern, and counts select-low and enabled steps. Those counts prove the manual select window, the read-phase tri-state and the dropped mid-word write at the pins.

// File: rtl/fhx_pkg.sv
`timescale 1ns/1ps
package fhx_pkg;
  localparam int WORD_W  = 32;
  localparam int LANES   = 8;
  localparam int BYTES   = WORD_W / 8;
  localparam int CNT_W   = $clog2(BYTES) + 1;
  localparam int SLICE_W = $clog2(LANES);

  localparam int OFS_CFG  = 'h00;
  localparam int OFS_STAT = 'h04;
  localparam int OFS_EN   = 'h08;
  localparam int OFS_TX0  = 'h14;
  localparam int OFS_RX   = 'h24;
  localparam int OFS_OP   = 'h28;
  localparam int OFS_LEN  = 'h2C;

  typedef enum logic [1:0] {PH_CMD = 2'd0, PH_ADDR = 2'd1, PH_DATA = 2'd2, PH_DATB = 2'd3} phase_e;

  // byte count chosen by the transmit alias index
  function automatic logic [CNT_W-1:0] alias_bytes(input logic [1:0] idx);
    return (idx == 2'd0) ? CNT_W'(BYTES) : CNT_W'(idx);
  endfunction

  // bus steps needed per byte for a lane code
  function automatic logic [SLICE_W:0] slices_of(input logic [1:0] code);
    return (SLICE_W+1)'(8 >> code);
  endfunction

  function automatic logic [1:0] phase_width(input phase_e ph, input logic [5:0] w);
    case (ph)
      PH_CMD:  return w[1:0];
      PH_ADDR: return w[3:2];
      default: return w[5:4];
    endcase
  endfunction

  // lanes for step sidx of one byte, msb first; unused lanes at idle
  function automatic logic [LANES-1:0] lane_slice(input logic [7:0] b, input logic [1:0] code,
                                                  input logic [SLICE_W-1:0] sidx, input logic idle);
    logic [LANES-1:0] r;
    int lanes, base;
    lanes = 1 << code;
    base  = 8 - lanes * (int'(sidx) + 1);
    for (int i = 0; i < LANES; i++) begin
      if (i < lanes && base + i >= 0 && base + i < 8) r[i] = b[3'(base + i)];
      else r[i] = idle;
    end
    return r;
  endfunction

  function automatic logic [7:0] shift_in(input logic [7:0] acc, input logic [LANES-1:0] din,
                                          input logic [1:0] code);
    case (code)
      2'd0:    return {acc[6:0], din[0]};
      2'd1:    return {acc[5:0], din[1:0]};
      2'd2:    return {acc[3:0], din[3:0]};
      default: return din[7:0];
    endcase
  endfunction
endpackage

// File: rtl/fhx_regs.sv
`timescale 1ns/1ps
module fhx_regs
  import fhx_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic              cs_assert_o,
  output logic              man_cs_o,
  output logic              idle_o,
  output logic              en_o,
  output logic [5:0]        widths_o,
  output phase_e            phase_o,
  output logic              rd_o,
  output logic [LEN_W-1:0]  len_o
);
  wire unused_wdata = ^wdata_i;

  wire wr_cfg = wr_i && (addr_i == ADDR_W'(OFS_CFG));
  wire wr_en  = wr_i && (addr_i == ADDR_W'(OFS_EN));
  wire wr_op  = wr_i && (addr_i == ADDR_W'(OFS_OP));
  wire wr_len = wr_i && (addr_i == ADDR_W'(OFS_LEN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_assert_o <= 1'b0;
      man_cs_o    <= 1'b0;
      idle_o      <= 1'b0;
      en_o        <= 1'b0;
      widths_o    <= '0;
      phase_o     <= PH_CMD;
      rd_o        <= 1'b0;
      len_o       <= '0;
    end else begin
      if (wr_cfg) begin
        cs_assert_o <= wdata_i[0];
        man_cs_o    <= wdata_i[1];
        idle_o      <= wdata_i[16];
      end
      if (wr_en) en_o <= wdata_i[0];
      if (wr_op) begin
        widths_o <= wdata_i[5:0];
        phase_o  <= phase_e'(wdata_i[9:8]);
        rd_o     <= wdata_i[23];
      end
      if (wr_len) len_o <= wdata_i[LEN_W-1:0];
    end
  end
endmodule

// File: rtl/fhx_shifter.sv
`timescale 1ns/1ps
module fhx_shifter
  import fhx_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               tx_wr_i,
  input  logic [1:0]         tx_idx_i,
  input  logic [WORD_W-1:0]  tx_data_i,
  input  logic [1:0]         wcode_i,
  input  logic               rd_i,
  input  logic               idle_i,
  input  logic [LANES-1:0]   dq_in_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [WORD_W-1:0]  rx_word_o,
  output logic [LANES-1:0]   dq_out_o,
  output logic               dq_oe_o
);
  logic [WORD_W-1:0]  tx_q, rx_acc_q;
  logic [CNT_W-1:0]   nbytes_q, bidx_q;
  logic [SLICE_W-1:0] sidx_q;
  logic [1:0]         wcode_q;
  logic               rd_q, busy_q;
  logic [7:0]         rx_byte_q;

  // named events
  wire accept_w     = tx_wr_i && en_i && !busy_q;
  wire last_slice_w = ({1'b0, sidx_q} == slices_of(wcode_q) - 1'b1);
  wire last_byte_w  = (bidx_q == nbytes_q - 1'b1);
  wire step_w       = busy_q && en_i;
  wire [7:0] byte_next_w = shift_in(rx_byte_q, dq_in_i, wcode_q);
  wire [7:0] cur_byte_w  = tx_q[{bidx_q[CNT_W-2:0], 3'b000} +: 8];

  assign busy_o    = busy_q;
  assign done_o    = step_w && last_slice_w && last_byte_w;
  assign rx_word_o = {byte_next_w, rx_acc_q[WORD_W-1:8]};
  assign dq_oe_o   = busy_q && !rd_q;
  assign dq_out_o  = dq_oe_o ? lane_slice(cur_byte_w, wcode_q, sidx_q, idle_i) : {LANES{idle_i}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      tx_q      <= '0;
      rx_acc_q  <= '0;
      nbytes_q  <= '0;
      bidx_q    <= '0;
      sidx_q    <= '0;
      wcode_q   <= '0;
      rd_q      <= 1'b0;
      rx_byte_q <= '0;
    end else if (!en_i) begin
      busy_q <= 1'b0;
      bidx_q <= '0;
      sidx_q <= '0;
    end else if (accept_w) begin
      busy_q    <= 1'b1;
      tx_q      <= tx_data_i;
      nbytes_q  <= alias_bytes(tx_idx_i);
      bidx_q    <= '0;
      sidx_q    <= '0;
      wcode_q   <= wcode_i;
      rd_q      <= rd_i;
      rx_acc_q  <= '0;
      rx_byte_q <= '0;
    end else if (busy_q) begin
      rx_byte_q <= byte_next_w;
      if (last_slice_w) begin
        sidx_q   <= '0;
        rx_acc_q <= rx_word_o;
        bidx_q   <= bidx_q + 1'b1;
        if (last_byte_w) busy_q <= 1'b0;
      end else begin
        sidx_q <= sidx_q + 1'b1;
      end
    end
  end

  // checker-side step counter, independent of the byte/slice indices
  logic [5:0] chk_steps_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chk_steps_q <= '0;
    else if (accept_w) chk_steps_q <= '0;
    else if (step_w) chk_steps_q <= chk_steps_q + 1'b1;
  end

  // R4
  word_length_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (chk_steps_q + 6'd1 == 6'(nbytes_q) * 6'(slices_of(wcode_q))));

  // R10
  inflight_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && en_i && !done_o) |=> $stable(tx_q));
endmodule

// File: rtl/fhx_rxbuf.sv
`timescale 1ns/1ps
module fhx_rxbuf
  import fhx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              consume_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (!en_i) begin
      valid_o <= 1'b0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= word_i;
    end else if (consume_i) begin
      valid_o <= 1'b0;
    end
  end

  // R9
  rx_post_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && en_i) |=> valid_o);

  // R9
  rx_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (consume_i && !load_i) |=> !valid_o);
endmodule

// File: rtl/fhx_engine.sv
`timescale 1ns/1ps
module fhx_engine
  import fhx_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              fl_cs_n,
  output logic              fl_shift,
  output logic [LANES-1:0]  fl_dq_out,
  output logic              fl_dq_oe,
  input  logic [LANES-1:0]  fl_dq_in
);
  logic cs_assert, man_cs, idle, en, rd, busy, done, rx_valid;
  logic [5:0] widths;
  phase_e phase;
  logic [LEN_W-1:0] len;
  logic [WORD_W-1:0] rx_word, rx_data;

  fhx_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(bus_wr), .addr_i(bus_addr), .wdata_i(bus_wdata),
    .cs_assert_o(cs_assert), .man_cs_o(man_cs), .idle_o(idle), .en_o(en),
    .widths_o(widths), .phase_o(phase), .rd_o(rd), .len_o(len));

  // transmit alias decode
  logic       tx_hit;
  logic [1:0] tx_idx;
  always_comb begin
    tx_hit = 1'b0;
    tx_idx = 2'd0;
    for (int k = 0; k < 4; k++) begin
      if (bus_addr == ADDR_W'(OFS_TX0 + 4 * k)) begin
        tx_hit = 1'b1;
        tx_idx = 2'(k);
      end
    end
  end
  wire tx_wr   = bus_wr && tx_hit;
  wire consume = bus_rd && (bus_addr == ADDR_W'(OFS_RX));

  fhx_shifter u_shift (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .tx_wr_i(tx_wr), .tx_idx_i(tx_idx),
    .tx_data_i(bus_wdata), .wcode_i(phase_width(phase, widths)), .rd_i(rd), .idle_i(idle),
    .dq_in_i(fl_dq_in), .busy_o(busy), .done_o(done), .rx_word_o(rx_word),
    .dq_out_o(fl_dq_out), .dq_oe_o(fl_dq_oe));

  fhx_rxbuf u_rx (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .load_i(done), .word_i(rx_word),
    .consume_i(consume), .valid_o(rx_valid), .data_o(rx_data));

  assign fl_shift = busy;
  assign fl_cs_n  = man_cs ? !cs_assert : !busy;

  always_comb begin
    bus_rdata = '0;
    case (int'(bus_addr))
      OFS_CFG:  bus_rdata = {15'd0, idle, 14'd0, man_cs, cs_assert};
      OFS_STAT: bus_rdata = {29'd0, rx_valid, 1'b0, !busy};
      OFS_EN:   bus_rdata = {31'd0, en};
      OFS_RX:   bus_rdata = rx_data;
      OFS_OP:   bus_rdata = {8'd0, rd, 13'd0, phase, 2'd0, widths};
      OFS_LEN:  bus_rdata = WORD_W'(len);
      default:  bus_rdata = '0;
    endcase
  end

  // R12
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);

  // R2
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tx_wr && en));
endmodule

// File: tb/fhx_engine_test.sv
`timescale 1ns/1ps
module fhx_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        fl_cs_n, fl_shift, fl_dq_oe;
  logic [7:0]  fl_dq_out;
  logic [7:0]  fl_dq_in = 8'h00;

  fhx_engine uut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fl_cs_n(fl_cs_n), .fl_shift(fl_shift),
    .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int cur_w = 1;
  logic [31:0] cur_dev = 32'h0;
  logic cur_idle = 1'b0;
  int mk = 0, shift_cnt = 0, oe_cnt = 0, cs_low_cnt = 0, up_bad = 0;
  logic [63:0] cap = 64'h0;

  // {op, alias index, tx word, device reply}
  localparam int NV = 9;
  localparam logic [97:0] VEC [NV] = '{
    {32'h0000_0003, 2'd1, 32'h0000_00A5, 32'h0000_003C},
    {32'h0000_010C, 2'd3, 32'h0012_3456, 32'h00C0_FFEE},
    {32'h0000_0200, 2'd0, 32'hDEAD_BEEF, 32'h8142_2418},
    {32'h0000_0210, 2'd2, 32'h0000_B00C, 32'h0000_7E5A},
    {32'h0000_0220, 2'd0, 32'h8765_4321, 32'h0F1E_2D3C},
    {32'h0080_0230, 2'd0, 32'hFFFF_FFFF, 32'hA1B2_C3D4},
    {32'h0080_0220, 2'd2, 32'hFFFF_FFFF, 32'h0000_9966},
    {32'h0000_0030, 2'd1, 32'h0000_005A, 32'h0000_00C3},
    {32'h0000_0320, 2'd3, 32'h00AB_CDEF, 32'h0011_2233}
  };

  function automatic logic [7:0] dev_slice(input int k);
    int bp, i, off;
    logic [7:0] b;
    bp = k * cur_w; i = bp / 8; off = bp % 8;
    if (i > 3) return 8'h00;
    b = cur_dev[8*i +: 8];
    return 8'((int'(b) >> (8 - off - cur_w)) & ((1 << cur_w) - 1));
  endfunction

  // flash-side model: records driven lanes, answers with cur_dev
  always @(negedge clk) begin
    if (fl_shift) begin
      if (mk == 0) cap = 64'h0;
      cap = (cap << cur_w) | (64'(fl_dq_out) & ((64'h1 << cur_w) - 64'h1));
      if (fl_dq_oe) oe_cnt++;
      if (!fl_cs_n) cs_low_cnt++;
      if (fl_dq_oe && ((fl_dq_out >> cur_w) != (cur_idle ? (8'hFF >> cur_w) : 8'h00))) up_bad++;
      fl_dq_in = dev_slice(mk);
      shift_cnt++;
      mk++;
    end else begin
      mk = 0;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5 d = bus_rdata;
  endtask

  task automatic run_xfer(input logic [31:0] op, input logic [1:0] idx,
                          input logic [31:0] tx, input logic [31:0] dev);
    int n, code, lat, oe0;
    logic [1:0] ph;
    logic [31:0] st, rx, exp_rx;
    logic [63:0] exp_s, m;
    ph = op[9:8];
    code = (ph == 2'd0) ? int'(op[1:0]) : (ph == 2'd1) ? int'(op[3:2]) : int'(op[5:4]);
    cur_w = 1 << code;
    cur_dev = dev;
    n = (idx == 2'd0) ? 4 : int'(idx);
    bus_write(8'h28, op);
    oe0 = oe_cnt;
    bus_write(8'h14 + 8'(4 * idx), tx);
    lat = 0; st = 0;
    while (st[2] == 1'b0 && lat < 100) begin
      @(posedge clk); #1;
      peek(8'h04, st);
      lat++;
    end
    check(lat == n * 8 / cur_w, "R3,R4,R6 word length", 64'(lat), 64'(n * 8 / cur_w));
    m = (64'h1 << (n * 8)) - 64'h1;
    if (!op[23]) begin
      exp_s = 64'h0;
      for (int i = 0; i < n; i++) exp_s = (exp_s << 8) | 64'(tx[8*i +: 8]);
      check((cap & m) == exp_s, "R5 byte order", cap & m, exp_s);
    end else begin
      check(oe_cnt == oe0 && (cap & m) == 64'(cur_idle ? m : 64'h0), "R8 read phase undriven",
            cap & m, cur_idle ? m : 64'h0);
    end
    exp_rx = 32'h0;
    for (int i = 0; i < n; i++) exp_rx = exp_rx | (32'(dev[8*i +: 8]) << (8 * (4 - n + i)));
    bus_read(8'h24, rx);
    check(rx == exp_rx, "R7 receive packing", 64'(rx), 64'(exp_rx));
    #1 peek(8'h04, st);
    check(st == 32'h1, "R9 status after consume", 64'(st), 64'h1);
  endtask

  initial begin
    logic [31:0] d;
    int sh0, cs0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1
    peek(8'h04, d); check(d == 32'h1, "R1 status", 64'(d), 64'h1);
    check(fl_cs_n == 1'b1 && fl_dq_oe == 1'b0 && fl_shift == 1'b0, "R1 pins",
          {fl_cs_n, fl_dq_oe, fl_shift}, 3'b100);
    check(fl_dq_out == 8'h00, "R1 idle lanes", 64'(fl_dq_out), 64'h0);
    peek(8'h00, d); check(d == 32'h0, "R1 config", 64'(d), 64'h0);
    peek(8'h08, d); check(d == 32'h0, "R1 enable", 64'(d), 64'h0);
    peek(8'h2C, d); check(d == 32'h0, "R1 length", 64'(d), 64'h0);

    // R2: disabled engine ignores transmit writes
    cur_w = 1; cur_dev = 32'h0;
    bus_write(8'h28, 32'h0);
    sh0 = shift_cnt;
    bus_write(8'h18, 32'h0000_00A5);
    repeat (20) @(posedge clk);
    #1 check(shift_cnt == sh0, "R2 no steps while disabled", 64'(shift_cnt - sh0), 64'h0);
    peek(8'h04, d); check(d == 32'h1, "R2 no receive word", 64'(d), 64'h1);

    // R14
    bus_write(8'h2C, 32'hFFFF_0123);
    #1 peek(8'h2C, d); check(d == 32'h0000_0123, "R14 length readback", 64'(d), 64'h123);

    bus_write(8'h08, 32'h1);
    #1 peek(8'h08, d); check(d == 32'h1, "R2 enable readback", 64'(d), 64'h1);

    // table walk, automatic chip-select
    sh0 = shift_cnt; cs0 = cs_low_cnt;
    for (int v = 0; v < NV; v++) run_xfer(VEC[v][97:66], VEC[v][65:64], VEC[v][63:32], VEC[v][31:0]);
    check(up_bad == 0, "R5 upper lanes idle", 64'(up_bad), 64'h0);
    check(cs_low_cnt - cs0 == shift_cnt - sh0, "R11 auto select follows word",
          64'(cs_low_cnt - cs0), 64'(shift_cnt - sh0));
    #1 check(fl_cs_n == 1'b1, "R11 auto select idle high", 64'(fl_cs_n), 64'h1);

    // R10: second write while the first word shifts is dropped
    bus_write(8'h28, 32'h0);
    cur_w = 1; cur_dev = 32'h0000_005C;
    sh0 = shift_cnt;
    bus_write(8'h18, 32'h0000_0096);
    bus_write(8'h14, 32'h1234_5678);
    d = 0;
    for (int t = 0; t < 40 && d[2] == 1'b0; t++) begin @(posedge clk); #1; peek(8'h04, d); end
    check((cap & 64'hFF) == 64'h96, "R10 word in flight intact", cap & 64'hFF, 64'h96);
    bus_read(8'h24, d);
    check(d == 32'h5C00_0000, "R10 receive of first word", 64'(d), 64'h5C00_0000);
    repeat (20) @(posedge clk);
    #1 check(shift_cnt - sh0 == 8, "R10 no second word", 64'(shift_cnt - sh0), 64'd8);
    peek(8'h04, d); check(d == 32'h1, "R10 status idle", 64'(d), 64'h1);

    // R13: idle level
    bus_write(8'h00, 32'h0001_0000);
    cur_idle = 1'b1;
    #1 check(fl_dq_out == 8'hFF, "R13 idle level high", 64'(fl_dq_out), 64'hFF);
    up_bad = 0;
    run_xfer(32'h0000_0210, 2'd2, 32'h0000_3C69, 32'h0000_1248);
    check(up_bad == 0, "R13 unused lanes at idle", 64'(up_bad), 64'h0);
    run_xfer(32'h0080_0200, 2'd1, 32'hFFFF_FFFF, 32'h0000_00B7);
    bus_write(8'h00, 32'h0);
    cur_idle = 1'b0;
    #1 check(fl_dq_out == 8'h00, "R13 idle level low", 64'(fl_dq_out), 64'h0);

    // R11: manual chip-select
    bus_write(8'h00, 32'h3);
    #1 check(fl_cs_n == 1'b0, "R11 manual assert", 64'(fl_cs_n), 64'h0);
    sh0 = shift_cnt; cs0 = cs_low_cnt;
    run_xfer(32'h0000_0003, 2'd1, 32'h0000_0080, 32'h0000_0011);
    #1 check(fl_cs_n == 1'b0, "R11 held between words", 64'(fl_cs_n), 64'h0);
    run_xfer(32'h0000_010C, 2'd2, 32'h0000_0201, 32'h0000_3344);
    check(cs_low_cnt - cs0 == shift_cnt - sh0, "R11 held across words",
          64'(cs_low_cnt - cs0), 64'(shift_cnt - sh0));
    bus_write(8'h00, 32'h2);
    #1 check(fl_cs_n == 1'b1, "R11 manual release", 64'(fl_cs_n), 64'h1);
    cs0 = cs_low_cnt;
    run_xfer(32'h0000_0230, 2'd1, 32'h0000_0042, 32'h0000_0024);
    check(cs_low_cnt == cs0, "R11 released stays high", 64'(cs_low_cnt - cs0), 64'h0);
    bus_write(8'h00, 32'h0);

    // R12: abort mid-word
    bus_write(8'h28, 32'h0000_0200);
    cur_w = 1; cur_dev = 32'hFFFF_FFFF;
    bus_write(8'h14, 32'hCAFE_F00D);
    repeat (3) @(posedge clk);
    bus_write(8'h08, 32'h0);
    @(posedge clk); #1;
    check(fl_shift == 1'b0 && fl_cs_n == 1'b1, "R12 stop after disable", {fl_shift, fl_cs_n}, 2'b01);
    peek(8'h04, d); check(d == 32'h1, "R12 status after abort", 64'(d), 64'h1);
    repeat (40) @(posedge clk);
    #1 peek(8'h04, d); check(d == 32'h1, "R12 no late receive word", 64'(d), 64'h1);
    bus_write(8'h08, 32'h1);
    run_xfer(32'h0000_0200, 2'd0, 32'h0102_0304, 32'h5566_7788);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule